// File: doc/BRIEF.md
# Receive Buffer Closure Controller

This block sits between a serial receiver and the logic that fills receive buffers in memory. It watches every received byte and decides when the current buffer has to be closed. There are two reasons to close a buffer. The first is that the byte just received equals one of four programmable match characters. The second is that a gap timer expires. The gap timer starts when the first byte enters an empty buffer, so it limits how long a partly filled buffer can stay open.

When a buffer closes, the block raises a one-cycle close pulse. In the same cycle it presents the final byte count and a 16-bit descriptor status word that says why the buffer closed. A descriptor writer downstream copies that word into the buffer descriptor. Sticky status flags keep the most recent reason visible until the next buffer opens or until the flags are cleared explicitly.

Top module: `rxCloseUnit`

## Requirements
- R1: Each match slot i (slot 0 is the first) is active only when `matchEn` is 1 and `matchCfg[i]` is 1. Its character is `matchChars[8*i +: 8]`. A received byte that equals an active slot's character closes the buffer. On closure, slot i is reported in `descStatus[15-i]` and in `statusMatch[3-i]`, so slot 0 maps to bit 15 and bit 3.
- R2: A byte that equals no active slot does not close the buffer and adds one to `byteCount`. This includes a byte that equals the character of a slot whose enable is off.
- R3: When one byte equals several active slots, all of their bits are set together in `descStatus[15:12]` and in `statusMatch`.
- R4: `closeStb` is high for exactly one cycle per closure, in the cycle after the closing edge. The matching byte is the last byte of the buffer: `closeCount` includes it, and `byteCount` reads 0 while `closeStb` is high.
- R5: With `gapEn` set, the timer is loaded from `gapReload` on the first byte of a buffer. It closes the buffer `max(gapReload,1)*PRESCALE` cycles after that byte, however many bytes arrive later. The closure sets `descStatus[11]` and `statusGap`, and `closeCount` equals the number of bytes received.
- R6: The gap timer never closes a buffer while `gapEn` is 0 or while the buffer is empty.
- R7: When a match byte arrives in the same cycle that the timer expires, only the match is reported, with `descStatus[11]` = 0. The byte is counted in `closeCount`.
- R8: `statusMatch` and `statusGap` hold their values after a closure. They clear on the first byte of the next buffer, unless that byte itself closes the buffer, or on a `statusClr` pulse.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One received byte is present this cycle |
| rxData | input | 8 | Received byte |
| matchEn | input | 1 | Global enable for character matching |
| matchCfg | input | 4 | Per-slot enable: bit i enables slot i |
| matchChars | input | 32 | Match characters: slot i is in bits 8*i+7 down to 8*i |
| gapEn | input | 1 | Enable for the gap timer |
| gapReload | input | 16 | Timeout in prescaled ticks |
| statusClr | input | 1 | Clears the sticky status flags |
| closeStb | output | 1 | One-cycle buffer close pulse |
| closeCount | output | 16 | Byte count of the closed buffer |
| descStatus | output | 16 | Descriptor status: bits 15:12 are the matches, bit 11 is the gap timeout |
| statusMatch | output | 4 | Sticky match flags, bit 3 = slot 0 |
| statusGap | output | 1 | Sticky gap-timeout flag |
| byteCount | output | 16 | Bytes in the currently open buffer |

## Verification
The assertions assume that `byteCount` never wraps. This means a buffer always closes, or the run ends, before 65535 bytes accumulate. The stimulus stays well inside this limit: the largest buffer in the bench is a few thousand bytes, collected while matching is disabled. The assertions also assume that the enables are stable for at least the cycle before the closure that they qualify. The bench changes enables only while no byte is in flight, so this holds. The gap runs keep their extra bytes different from every active match character, so that each timeout is measured on a buffer that only the timer can close.

// File: rtl/rxclose_pkg.sv
package rxclose_pkg;
  typedef struct packed {
    logic acceptByte;
    logic firstByte;
    logic closeMatch;
    logic closeGap;
  } closeStrobes_t;
endpackage

// File: rtl/rxcloseCtrl.sv
module rxcloseCtrl
  import rxclose_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             anyHit,
  input  logic             gapEn,
  input  logic [TMR_W-1:0] gapReload,
  output closeStrobes_t    strb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic             bufOpenQ;
  logic [PRE_W-1:0] preQ;
  logic [TMR_W-1:0] timerQ;
  logic             tick;
  logic             running;
  logic             expire;

  assign running = bufOpenQ & gapEn;
  assign tick    = (preQ == PRE_LAST);
  assign expire  = running & tick & (timerQ <= TMR_W'(1));

  // a match takes precedence over a timer expiry in the same cycle
  always_comb begin
    strb.acceptByte = rxValid;
    strb.firstByte  = rxValid & ~bufOpenQ;
    strb.closeMatch = rxValid & anyHit;
    strb.closeGap   = expire & ~(rxValid & anyHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufOpenQ <= 1'b0;
      preQ     <= '0;
      timerQ   <= '0;
    end else begin
      if (strb.closeMatch || strb.closeGap) bufOpenQ <= 1'b0;
      else if (rxValid)                     bufOpenQ <= 1'b1;

      if (strb.firstByte) begin
        timerQ <= gapReload;
        preQ   <= '0;
      end else if (running) begin
        preQ <= tick ? '0 : preQ + PRE_W'(1);
        if (tick && timerQ != '0) timerQ <= timerQ - TMR_W'(1);
      end
    end
  end

  // R6: an empty buffer leaves the timer untouched
  a_r6_idle_timer: assert property (@(posedge clk) disable iff (!rstN)
    (!bufOpenQ && !rxValid) |=> $stable(timerQ));

  // R6: the prescaler is frozen while the timer is not running
  a_r6_idle_prescale: assert property (@(posedge clk) disable iff (!rstN)
    (!bufOpenQ && !rxValid) |=> $stable(preQ));
endmodule

// File: rtl/rxcloseDatapath.sv
module rxcloseDatapath
  import rxclose_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [DATA_W-1:0]           rxData,
  input  logic                        matchEn,
  input  logic [NUM_MATCH-1:0]        matchCfg,
  input  logic [NUM_MATCH*DATA_W-1:0] matchChars,
  input  logic                        gapEn,
  input  logic                        statusClr,
  input  closeStrobes_t               strb,
  output logic                        anyHit,
  output logic                        closeStb,
  output logic [CNT_W-1:0]            closeCount,
  output logic [15:0]                 descStatus,
  output logic [NUM_MATCH-1:0]        statusMatch,
  output logic                        statusGap,
  output logic [CNT_W-1:0]            byteCount
);
  localparam int DESC_GAP_BIT   = 11;
  localparam int DESC_MATCH_LSB = 12;

  logic [NUM_MATCH-1:0] hitVec;
  logic [NUM_MATCH-1:0] matchNib;
  logic [15:0]          descNext;
  logic [CNT_W-1:0]     countQ;
  logic                 closeAny;

  for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_cmp
    assign hitVec[gi] = matchEn & matchCfg[gi] &
                        (rxData == matchChars[gi*DATA_W +: DATA_W]);
    assign matchNib[NUM_MATCH-1-gi] = hitVec[gi];
  end

  assign anyHit   = |hitVec;
  assign closeAny = strb.closeMatch | strb.closeGap;

  always_comb begin
    descNext = '0;
    descNext[DESC_GAP_BIT] = strb.closeGap;
    if (strb.closeMatch) descNext[DESC_MATCH_LSB +: NUM_MATCH] = matchNib;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closeStb    <= 1'b0;
      closeCount  <= '0;
      descStatus  <= '0;
      statusMatch <= '0;
      statusGap   <= 1'b0;
      countQ      <= '0;
    end else begin
      closeStb <= closeAny;
      if (closeAny) begin
        closeCount  <= countQ + CNT_W'(strb.acceptByte);
        descStatus  <= descNext;
        statusMatch <= strb.closeMatch ? matchNib : '0;
        statusGap   <= strb.closeGap;
        countQ      <= '0;
      end else begin
        if (strb.acceptByte) countQ <= countQ + CNT_W'(1);
        if (strb.firstByte || statusClr) begin
          statusMatch <= '0;
          statusGap   <= 1'b0;
        end
      end
    end
  end

  assign byteCount = countQ;

  // R4: the running count is already cleared when the pulse is seen
  a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    closeStb |-> (byteCount == '0));

  // R4: a closed buffer always holds at least one byte
  a_r4_close_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    closeStb |-> (closeCount != '0));

  // R7: exactly one closure reason is reported
  a_r7_single_reason: assert property (@(posedge clk) disable iff (!rstN)
    closeStb |-> !(descStatus[DESC_GAP_BIT] &&
                   (descStatus[DESC_MATCH_LSB +: NUM_MATCH] != '0)));

  // R2: match reasons require the global enable
  a_r2_match_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (closeStb && descStatus[DESC_MATCH_LSB +: NUM_MATCH] != '0) |-> $past(matchEn));

  // R6: gap reasons require the timer enable
  a_r6_gap_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (closeStb && descStatus[DESC_GAP_BIT]) |-> $past(gapEn));
endmodule

// File: rtl/rxCloseUnit.sv
module rxCloseUnit
  import rxclose_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 16,
  parameter int TMR_W     = 16,
  parameter int PRESCALE  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxValid,
  input  logic [DATA_W-1:0]           rxData,
  input  logic                        matchEn,
  input  logic [NUM_MATCH-1:0]        matchCfg,
  input  logic [NUM_MATCH*DATA_W-1:0] matchChars,
  input  logic                        gapEn,
  input  logic [TMR_W-1:0]            gapReload,
  input  logic                        statusClr,
  output logic                        closeStb,
  output logic [CNT_W-1:0]            closeCount,
  output logic [15:0]                 descStatus,
  output logic [NUM_MATCH-1:0]        statusMatch,
  output logic                        statusGap,
  output logic [CNT_W-1:0]            byteCount
);
  closeStrobes_t strb;
  logic          anyHit;

  rxcloseCtrl #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .anyHit(anyHit),
    .gapEn(gapEn), .gapReload(gapReload), .strb(strb)
  );

  rxcloseDatapath #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .matchEn(matchEn),
    .matchCfg(matchCfg), .matchChars(matchChars), .gapEn(gapEn),
    .statusClr(statusClr), .strb(strb), .anyHit(anyHit),
    .closeStb(closeStb), .closeCount(closeCount), .descStatus(descStatus),
    .statusMatch(statusMatch), .statusGap(statusGap), .byteCount(byteCount)
  );
endmodule

// File: tb/rxCloseUnit_tb_top.sv
module rxCloseUnit_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rxValid;
  logic [7:0]  rxData;
  logic        matchEn;
  logic [3:0]  matchCfg;
  logic [31:0] matchChars;
  logic        gapEn;
  logic [15:0] gapReload;
  logic        statusClr;
  logic        closeStb;
  logic [15:0] closeCount;
  logic [15:0] descStatus;
  logic [3:0]  statusMatch;
  logic        statusGap;
  logic [15:0] byteCount;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxCloseUnit #(.PRESCALE(P)) dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .matchEn(matchEn), .matchCfg(matchCfg), .matchChars(matchChars),
    .gapEn(gapEn), .gapReload(gapReload), .statusClr(statusClr),
    .closeStb(closeStb), .closeCount(closeCount), .descStatus(descStatus),
    .statusMatch(statusMatch), .statusGap(statusGap), .byteCount(byteCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d);
    rxValid = 1'b1;
    rxData  = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // first byte, optional extra bytes, optional match byte at cycle matchAt
  task automatic gapRun(input int reload, input int nExtra, input int matchAt);
    int closedAt = 0;
    int expT = ((reload == 0) ? 1 : reload) * P;
    bit pri = (matchAt == expT);
    int expCnt = 1 + nExtra + (pri ? 1 : 0);
    gapReload = 16'(reload);
    sendByte(8'h41);
    for (int j = 1; j <= 200; j++) begin
      if (j <= nExtra) begin rxValid = 1'b1; rxData = 8'h42; end
      else if (j == matchAt) begin rxValid = 1'b1; rxData = 8'h0D; end
      else rxValid = 1'b0;
      @(negedge clk);
      rxValid = 1'b0;
      if (closeStb) begin closedAt = j; break; end
    end
    chk(closedAt == expT, "R5 close delay", closedAt, expT);
    chk(closeCount == 16'(expCnt), pri ? "R7 count" : "R5 count", closeCount, expCnt);
    chk(byteCount == 0, "R4 count cleared", byteCount, 0);
    if (pri) begin
      chk(descStatus == 16'h8000, "R7 match wins", descStatus, 16'h8000);
      chk(statusGap == 1'b0 && statusMatch == 4'b1000, "R7 status",
          {statusGap, statusMatch}, 5'b01000);
    end else begin
      chk(descStatus == 16'h0800, "R5 gap bit", descStatus, 16'h0800);
      chk(statusGap == 1'b1, "R5 status gap", statusGap, 1);
    end
    @(negedge clk);
    chk(closeStb == 1'b0, "R4 single pulse", closeStb, 0);
  endtask

  initial begin
    logic [7:0] ch [4];
    int cnt;
    logic [3:0] sm;
    bit open;
    bit seen;
    ch[0] = 8'h0D; ch[1] = 8'h7E; ch[2] = 8'h0D; ch[3] = 8'hFF;
    rstN = 1'b0; rxValid = 1'b0; rxData = '0; matchEn = 1'b0; matchCfg = '0;
    matchChars = {ch[3], ch[2], ch[1], ch[0]};
    gapEn = 1'b0; gapReload = '0; statusClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(closeStb == 0 && closeCount == 0 && descStatus == 0, "R9 reset outputs",
        {closeStb, closeCount, descStatus}, 0);
    chk(statusMatch == 0 && statusGap == 0 && byteCount == 0, "R9 reset status",
        {statusMatch, statusGap, byteCount}, 0);

    // exhaustive byte sweep over every enable combination
    cnt = 0; sm = '0; open = 1'b0;
    for (int en = 0; en < 2; en++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        matchEn = en[0]; matchCfg = cfg[3:0];
        for (int d = 0; d < 256; d++) begin
          logic [3:0] nib = '0;
          for (int i = 0; i < 4; i++)
            nib[3-i] = en[0] & cfg[i] & (d[7:0] == ch[i]);
          sendByte(d[7:0]);
          if (nib != 0) begin
            chk(closeStb == 1'b1, "R1 close on match", closeStb, 1);
            chk(descStatus == {nib, 12'h000}, ($countones(nib) > 1) ? "R3 multi bits" : "R1 bit position",
                descStatus, {nib, 12'h000});
            chk(closeCount == 16'(cnt + 1), "R4 final count", closeCount, cnt + 1);
            chk(byteCount == 0, "R4 count cleared", byteCount, 0);
            cnt = 0; sm = nib; open = 1'b0;
          end else begin
            chk(closeStb == 1'b0, "R2 no close", closeStb, 0);
            chk(byteCount == 16'(cnt + 1), "R2 byte counted", byteCount, cnt + 1);
            if (!open) sm = '0;
            open = 1'b1; cnt++;
          end
          chk(statusMatch == sm, "R8 sticky match", statusMatch, sm);
        end
      end
    end

    // explicit clear of sticky flags
    matchEn = 1'b1; matchCfg = 4'b0001;
    sendByte(8'h0D);
    chk(statusMatch == 4'b1000, "R1 slot0 status", statusMatch, 4'b1000);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    chk(statusMatch == 0, "R8 clear pulse", statusMatch, 0);

    // timer enabled but buffer empty: nothing happens
    gapEn = 1'b1; gapReload = 16'd1; seen = 1'b0;
    repeat (40) begin @(negedge clk); if (closeStb) seen = 1'b1; end
    chk(!seen, "R6 empty buffer idle", seen, 0);

    for (int r = 0; r <= 5; r++) gapRun(r, r % 3, 0);
    gapRun(3, 2, 3 * P);
    gapRun(2, 1, 2 * P);
    gapRun(7, 0, 0);

    // sticky gap hold, clear on next first byte, and no expiry while disabled
    chk(statusGap == 1'b1, "R8 gap held", statusGap, 1);
    gapEn = 1'b0;
    @(negedge clk);
    chk(statusGap == 1'b1, "R8 gap still held", statusGap, 1);
    sendByte(8'h43);
    chk(statusGap == 1'b0, "R8 gap cleared by new buffer", statusGap, 0);
    chk(byteCount == 1, "R2 open count", byteCount, 1);
    seen = 1'b0;
    repeat (60) begin @(negedge clk); if (closeStb) seen = 1'b1; end
    chk(!seen, "R6 disabled timer", seen, 0);
    sendByte(8'h0D);
    chk(closeStb == 1'b1 && closeCount == 2, "R4 close after idle", closeCount, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule